// File: doc/BRIEF.md
# Interrupt Context Stack Sequencer

This block is the part of a small 8-bit processor core that moves processor context between the register file and a byte-wide stack in memory. The stack grows toward lower addresses. The decoder hands the block a command together with the current register values. The block then walks a fixed schedule of single-byte memory accesses. It returns restored values through one-cycle load strobes, and it signals completion with a one-cycle done pulse. Decoding and arithmetic stay outside the block.

Six operations are supported:
- software interrupt: store the seven-byte context frame, mask interrupts, fetch the service address from a fixed vector pair;
- interrupt return: reload the whole frame;
- wait: store the frame, then idle until a wake-up is accepted;
- subroutine return: reload the program counter;
- push of either accumulator;
- pull of either accumulator.

Each memory access occupies exactly one clock. Idle cycles pad every operation to its fixed length.

Top module: `ctx_stack_seq`

## Requirements
- R1: A command is taken on a rising edge where `cmd_valid` is high and `busy` is low. On that edge `busy` rises, and the register inputs are sampled as the working context. Codes: 0 software interrupt, 1 interrupt return, 2 wait, 3 subroutine return, 4 push A, 5 push B, 6 pull A, 7 pull B. While `busy` is high, `cmd_valid` has no effect.
- R2: After reset, and in every cycle where `busy` is low, `busy`, `done`, both memory strobes and all load strobes are low.
- R3: Software interrupt and wait write the frame in their first seven busy cycles, one byte per cycle. The addresses are SP, SP-1, SP-2, SP-3, SP-4, SP-5, SP-6 and the bytes are, in that order, PC low, PC high, X low, X high, A, B, flags. `mem_we` and `mem_re` are never high together.
- R4: Software interrupt loads SP-7 into SP and loads the flags with the mask bit (bit 4) forced to 1. It then reads 0xFFFA as the high byte and 0xFFFB as the low byte, and loads PC with that pair.
- R5: Interrupt return reads SP+1 through SP+7 in ascending order. The bytes go to flags, B, A, X high, X low, PC high, PC low. X and PC each load once as 16-bit values, and SP loads SP+7.
- R6: Subroutine return reads SP+1 (PC high) then SP+2 (PC low), loads PC, then loads SP+2.
- R7: Push writes the chosen accumulator at SP, then loads SP-1. Pull reads SP+1 into the chosen accumulator, then loads SP+1. Bit 0 of the code selects B.
- R8: Wait loads SP-7 after the frame and then holds in a wait state. With the saved mask bit at 1, `irq` is ignored and only `nmi` ends the wait. With the mask bit at 0, either line ends it. On exit the flags load with the mask bit set.
- R9: `busy` stays high for exactly 12 cycles for software interrupt, 10 for interrupt return, 5 for subroutine return and 4 for push or pull. For wait it stays high for 9 cycles up to and including the first wait cycle, plus one exit cycle, so 10 in total when a wake-up is already present.
- R10: Each load strobe is a one-cycle pulse in the cycle after the step that produced it. `done` is a one-cycle pulse in the first cycle after the last busy cycle, which is later than every load strobe of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd | input | 3 | Command code (see R1) |
| pc_in | input | 16 | Current program counter |
| x_in | input | 16 | Current index register |
| a_in | input | 8 | Current accumulator A |
| b_in | input | 8 | Current accumulator B |
| flg_in | input | 8 | Current flags byte, bit 4 is the interrupt mask |
| sp_in | input | 16 | Current stack pointer |
| irq | input | 1 | Maskable interrupt request |
| nmi | input | 1 | Non-maskable interrupt request |
| mem_rdata | input | 8 | Read data, valid in the cycle of `mem_re` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| pc_ld | output | 1 | Program counter load strobe |
| pc_out | output | 16 | Program counter load value |
| x_ld | output | 1 | Index register load strobe |
| x_out | output | 16 | Index register load value |
| a_ld | output | 1 | Accumulator A load strobe |
| a_out | output | 8 | Accumulator A load value |
| b_ld | output | 1 | Accumulator B load strobe |
| b_out | output | 8 | Accumulator B load value |
| flg_ld | output | 1 | Flags load strobe |
| flg_out | output | 8 | Flags load value |
| sp_ld | output | 1 | Stack pointer load strobe |
| sp_out | output | 16 | Stack pointer load value |

## Verification
Two things can land in the same cycle and must not interact.

The first pair is the interrupt lines and frame saving. The bench raises `irq` before and during the frame writes of a wait whose saved mask is set. It then checks that the block stays busy, with no done pulse, until `nmi` arrives. A second wait runs with the mask clear and `irq` already high; that one must leave after exactly ten busy cycles.

The second pair is a new request and an operation already running. The bench holds `cmd_valid` with a subroutine-return code during the second cycle of a push. It then confirms that exactly one write happened, that no read or PC load followed, and that the block went idle afterwards.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;

    localparam int DW     = 8;
    localparam int AW     = 2 * DW;
    localparam int STEP_W = 4;
    localparam int OFF_W  = 4;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] word_t;

    typedef enum logic [2:0] {
        CMD_SWI  = 3'd0,
        CMD_RTI  = 3'd1,
        CMD_WAI  = 3'd2,
        CMD_RTS  = 3'd3,
        CMD_PSHA = 3'd4,
        CMD_PSHB = 3'd5,
        CMD_PULA = 3'd6,
        CMD_PULB = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {BUS_NONE, BUS_WR, BUS_RD} bus_e;

    // order of the first seven entries equals the frame write order
    typedef enum logic [2:0] {
        SRC_PCL, SRC_PCH, SRC_XL, SRC_XH, SRC_A, SRC_B, SRC_FLG, SRC_ACC
    } src_e;

    typedef enum logic [3:0] {
        DST_NONE, DST_FLG, DST_A, DST_B, DST_HOLD, DST_X, DST_PC, DST_ACC, DST_FLGMASK
    } dst_e;

    typedef struct packed {
        word_t pc;
        word_t x;
        byte_t a;
        byte_t b;
        byte_t flg;
        word_t sp;
    } ctx_t;

    typedef struct packed {
        bus_e                    bus;
        logic                    vec;
        logic signed [OFF_W-1:0] off;
        src_e                    src;
        dst_e                    dst;
        logic                    sp_upd;
        logic signed [OFF_W-1:0] sp_adj;
        logic                    hold;
        logic                    last;
    } step_t;

    function automatic word_t sext_off(input logic signed [OFF_W-1:0] v);
        return {{(AW-OFF_W){v[OFF_W-1]}}, v};
    endfunction

    // action taken by one command in one step
    function automatic step_t plan_step(input cmd_e c, input logic [STEP_W-1:0] s);
        step_t t;
        t        = '0;
        t.bus    = BUS_NONE;
        t.src    = SRC_PCL;
        t.dst    = DST_NONE;
        case (c)
            CMD_SWI, CMD_WAI: begin
                if (s <= 4'd6) begin
                    t.bus = BUS_WR;
                    t.off = -$signed({1'b0, s[2:0]});
                    t.src = src_e'(s[2:0]);
                end else if (s == 4'd7) begin
                    t.sp_upd = 1'b1;
                    t.sp_adj = -4'sd7;
                    if (c == CMD_SWI) t.dst = DST_FLGMASK;
                end else if (c == CMD_SWI) begin
                    if (s == 4'd8) begin
                        t.bus = BUS_RD; t.vec = 1'b1; t.off = 4'sd0; t.dst = DST_HOLD;
                    end else if (s == 4'd9) begin
                        t.bus = BUS_RD; t.vec = 1'b1; t.off = 4'sd1; t.dst = DST_PC;
                    end else if (s == 4'd11) begin
                        t.last = 1'b1;
                    end
                end else begin
                    if (s == 4'd8) begin
                        t.hold = 1'b1;
                        t.dst  = DST_FLGMASK;
                    end else if (s == 4'd9) begin
                        t.last = 1'b1;
                    end
                end
            end
            CMD_RTI: begin
                if (s >= 4'd1 && s <= 4'd7) begin
                    t.bus = BUS_RD;
                    t.off = $signed({1'b0, s[2:0]});
                    case (s[2:0])
                        3'd1:    t.dst = DST_FLG;
                        3'd2:    t.dst = DST_B;
                        3'd3:    t.dst = DST_A;
                        3'd5:    t.dst = DST_X;
                        3'd7:    t.dst = DST_PC;
                        default: t.dst = DST_HOLD;
                    endcase
                end else if (s == 4'd8) begin
                    t.sp_upd = 1'b1;
                    t.sp_adj = 4'sd7;
                end else if (s == 4'd9) begin
                    t.last = 1'b1;
                end
            end
            CMD_RTS: begin
                if (s == 4'd1) begin
                    t.bus = BUS_RD; t.off = 4'sd1; t.dst = DST_HOLD;
                end else if (s == 4'd2) begin
                    t.bus = BUS_RD; t.off = 4'sd2; t.dst = DST_PC;
                end else if (s == 4'd3) begin
                    t.sp_upd = 1'b1; t.sp_adj = 4'sd2;
                end else if (s == 4'd4) begin
                    t.last = 1'b1;
                end
            end
            CMD_PSHA, CMD_PSHB: begin
                if (s == 4'd0) begin
                    t.bus = BUS_WR; t.off = 4'sd0; t.src = SRC_ACC;
                end else if (s == 4'd1) begin
                    t.sp_upd = 1'b1; t.sp_adj = -4'sd1;
                end else if (s == 4'd3) begin
                    t.last = 1'b1;
                end
            end
            default: begin
                if (s == 4'd1) begin
                    t.bus = BUS_RD; t.off = 4'sd1; t.dst = DST_ACC;
                end else if (s == 4'd2) begin
                    t.sp_upd = 1'b1; t.sp_adj = 4'sd1;
                end else if (s == 4'd3) begin
                    t.last = 1'b1;
                end
            end
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ctx_step_decode.sv
module ctx_step_decode
    import ctx_stack_pkg::*;
(
    input  cmd_e              cmd,
    input  logic [STEP_W-1:0] step,
    output step_t             act
);
    assign act = plan_step(cmd, step);
endmodule

// File: rtl/ctx_bus_drive.sv
module ctx_bus_drive
    import ctx_stack_pkg::*;
#(
    parameter word_t VEC_ADDR = 16'hFFFA
) (
    input  logic                    active,
    input  bus_e                    bus,
    input  logic                    vec,
    input  logic signed [OFF_W-1:0] off,
    input  src_e                    src,
    input  logic                    acc_b,
    input  ctx_t                    ctx,
    output word_t                   addr,
    output byte_t                   wdata,
    output logic                    we,
    output logic                    re
);
    word_t base;

    always_comb begin
        base  = vec ? VEC_ADDR : ctx.sp;
        we    = active && (bus == BUS_WR);
        re    = active && (bus == BUS_RD);
        addr  = (we || re) ? base + sext_off(off) : '0;
        wdata = '0;
        if (we) begin
            case (src)
                SRC_PCL: wdata = ctx.pc[DW-1:0];
                SRC_PCH: wdata = ctx.pc[AW-1:DW];
                SRC_XL:  wdata = ctx.x[DW-1:0];
                SRC_XH:  wdata = ctx.x[AW-1:DW];
                SRC_A:   wdata = ctx.a;
                SRC_B:   wdata = ctx.b;
                SRC_FLG: wdata = ctx.flg;
                default: wdata = acc_b ? ctx.b : ctx.a;
            endcase
        end
    end
endmodule

// File: rtl/ctx_load_unit.sv
module ctx_load_unit
    import ctx_stack_pkg::*;
#(
    parameter int MASK_BIT = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    apply,
    input  dst_e                    dst,
    input  logic                    sp_upd,
    input  logic signed [OFF_W-1:0] sp_adj,
    input  logic                    acc_b,
    input  word_t                   sp_base,
    input  byte_t                   flg_base,
    input  byte_t                   rdata,
    output logic                    pc_ld,
    output word_t                   pc_val,
    output logic                    x_ld,
    output word_t                   x_val,
    output logic                    a_ld,
    output byte_t                   a_val,
    output logic                    b_ld,
    output byte_t                   b_val,
    output logic                    flg_ld,
    output byte_t                   flg_val,
    output logic                    sp_ld,
    output word_t                   sp_val
);
    localparam byte_t MASK_ONE = byte_t'(1) << MASK_BIT;

    byte_t hold_q;
    logic  to_b;

    assign to_b = (dst == DST_B) || (dst == DST_ACC && acc_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            pc_ld  <= 1'b0; pc_val  <= '0;
            x_ld   <= 1'b0; x_val   <= '0;
            a_ld   <= 1'b0; a_val   <= '0;
            b_ld   <= 1'b0; b_val   <= '0;
            flg_ld <= 1'b0; flg_val <= '0;
            sp_ld  <= 1'b0; sp_val  <= '0;
        end else begin
            pc_ld  <= 1'b0;
            x_ld   <= 1'b0;
            a_ld   <= 1'b0;
            b_ld   <= 1'b0;
            flg_ld <= 1'b0;
            sp_ld  <= 1'b0;
            if (apply) begin
                if (sp_upd) begin
                    sp_ld  <= 1'b1;
                    sp_val <= sp_base + sext_off(sp_adj);
                end
                case (dst)
                    DST_FLG: begin
                        flg_ld <= 1'b1; flg_val <= rdata;
                    end
                    DST_FLGMASK: begin
                        flg_ld <= 1'b1; flg_val <= flg_base | MASK_ONE;
                    end
                    DST_A, DST_B, DST_ACC: begin
                        if (to_b) begin
                            b_ld <= 1'b1; b_val <= rdata;
                        end else begin
                            a_ld <= 1'b1; a_val <= rdata;
                        end
                    end
                    DST_HOLD: hold_q <= rdata;
                    DST_X: begin
                        x_ld <= 1'b1; x_val <= {hold_q, rdata};
                    end
                    DST_PC: begin
                        pc_ld <= 1'b1; pc_val <= {hold_q, rdata};
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
    import ctx_stack_pkg::*;
#(
    parameter logic [15:0] VEC_ADDR = 16'hFFFA,
    parameter int          MASK_BIT = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd,
    input  logic [15:0] pc_in,
    input  logic [15:0] x_in,
    input  logic [7:0]  a_in,
    input  logic [7:0]  b_in,
    input  logic [7:0]  flg_in,
    input  logic [15:0] sp_in,
    input  logic        irq,
    input  logic        nmi,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        mem_we,
    output logic        mem_re,
    output logic        pc_ld,
    output logic [15:0] pc_out,
    output logic        x_ld,
    output logic [15:0] x_out,
    output logic        a_ld,
    output logic [7:0]  a_out,
    output logic        b_ld,
    output logic [7:0]  b_out,
    output logic        flg_ld,
    output logic [7:0]  flg_out,
    output logic        sp_ld,
    output logic [15:0] sp_out
);
    cmd_e              cmd_q;
    logic [STEP_W-1:0] step_q;
    ctx_t              ctx_q;
    step_t             act;
    logic              masked;
    logic              wake;
    logic              in_wait;
    logic              advance;
    logic              acc_b;

    assign acc_b   = cmd_q[0];
    assign masked  = ctx_q.flg[MASK_BIT];
    assign wake    = nmi || (irq && !masked);
    assign in_wait = busy && act.hold;
    assign advance = busy && !(in_wait && !wake);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            step_q <= '0;
            cmd_q  <= CMD_SWI;
            ctx_q  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (cmd_valid) begin
                    busy   <= 1'b1;
                    step_q <= '0;
                    cmd_q  <= cmd_e'(cmd);
                    ctx_q  <= '{pc: pc_in, x: x_in, a: a_in, b: b_in, flg: flg_in, sp: sp_in};
                end
            end else if (advance) begin
                if (act.last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    step_q <= step_q + 1'b1;
                end
            end
        end
    end

    ctx_step_decode u_dec (
        .cmd  (cmd_q),
        .step (step_q),
        .act  (act)
    );

    ctx_bus_drive #(.VEC_ADDR(VEC_ADDR)) u_bus (
        .active (busy),
        .bus    (act.bus),
        .vec    (act.vec),
        .off    (act.off),
        .src    (act.src),
        .acc_b  (acc_b),
        .ctx    (ctx_q),
        .addr   (mem_addr),
        .wdata  (mem_wdata),
        .we     (mem_we),
        .re     (mem_re)
    );

    ctx_load_unit #(.MASK_BIT(MASK_BIT)) u_load (
        .clk      (clk),
        .rst      (rst),
        .apply    (advance),
        .dst      (act.dst),
        .sp_upd   (act.sp_upd),
        .sp_adj   (act.sp_adj),
        .acc_b    (acc_b),
        .sp_base  (ctx_q.sp),
        .flg_base (ctx_q.flg),
        .rdata    (mem_rdata),
        .pc_ld    (pc_ld),
        .pc_val   (pc_out),
        .x_ld     (x_ld),
        .x_val    (x_out),
        .a_ld     (a_ld),
        .a_val    (a_out),
        .b_ld     (b_ld),
        .b_val    (b_out),
        .flg_ld   (flg_ld),
        .flg_val  (flg_out),
        .sp_ld    (sp_ld),
        .sp_val   (sp_out)
    );
endmodule

// File: rtl/ctx_stack_seq_chk.sv
module ctx_stack_seq_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic busy,
    input logic done,
    input logic mem_we,
    input logic mem_re,
    input logic nmi,
    input logic masked,
    input logic in_wait,
    input logic any_ld
);
    a_r3_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_we || mem_re || any_ld));

    a_r1_accept: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid) |=> busy);

    a_r8_masked_hold: assert property (@(posedge clk) disable iff (rst)
        (in_wait && masked && !nmi) |=> in_wait);

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r10_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
endmodule

bind ctx_stack_seq ctx_stack_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .nmi       (nmi),
    .masked    (masked),
    .in_wait   (in_wait),
    .any_ld    (pc_ld || x_ld || a_ld || b_ld || flg_ld || sp_ld)
);

// File: tb/ctx_stack_seq_test.sv
module ctx_stack_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd;
    logic [15:0] pc_in, x_in, sp_in;
    logic [7:0]  a_in, b_in, flg_in;
    logic        irq, nmi;
    logic [7:0]  mem_rdata;
    logic        busy, done, mem_we, mem_re;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        pc_ld, x_ld, a_ld, b_ld, flg_ld, sp_ld;
    logic [15:0] pc_out, x_out, sp_out;
    logic [7:0]  a_out, b_out, flg_out;

    always #10 clk = ~clk;

    ctx_stack_seq uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
        .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .b_in(b_in), .flg_in(flg_in), .sp_in(sp_in),
        .irq(irq), .nmi(nmi), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re),
        .pc_ld(pc_ld), .pc_out(pc_out), .x_ld(x_ld), .x_out(x_out),
        .a_ld(a_ld), .a_out(a_out), .b_ld(b_ld), .b_out(b_out),
        .flg_ld(flg_ld), .flg_out(flg_out), .sp_ld(sp_ld), .sp_out(sp_out)
    );

    // byte memory keyed by the low address byte
    logic [7:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    int n_chk = 0;
    int n_err = 0;

    // observation of one operation
    logic        mon_on = 1'b0;
    int          cyc, busy_cyc, wr_n, rd_n, done_n, last_ld_cyc, done_cyc;
    int          pc_n, x_n, a_n, b_n, f_n, sp_n;
    logic [15:0] wr_a [0:15];
    logic [7:0]  wr_d [0:15];
    logic [15:0] rd_a [0:15];
    logic [15:0] pc_g, x_g, sp_g;
    logic [7:0]  a_g, b_g, f_g;

    always @(negedge clk) if (mon_on) begin
        cyc++;
        if (busy) busy_cyc++;
        if (mem_we) begin
            if (wr_n < 16) begin wr_a[wr_n] = mem_addr; wr_d[wr_n] = mem_wdata; end
            wr_n++;
        end
        if (mem_re) begin
            if (rd_n < 16) rd_a[rd_n] = mem_addr;
            rd_n++;
        end
        if (pc_ld)  begin pc_n++; pc_g = pc_out;  end
        if (x_ld)   begin x_n++;  x_g  = x_out;   end
        if (a_ld)   begin a_n++;  a_g  = a_out;   end
        if (b_ld)   begin b_n++;  b_g  = b_out;   end
        if (flg_ld) begin f_n++;  f_g  = flg_out; end
        if (sp_ld)  begin sp_n++; sp_g = sp_out;  end
        if (pc_ld || x_ld || a_ld || b_ld || flg_ld || sp_ld) last_ld_cyc = cyc;
        if (done) begin done_n++; done_cyc = cyc; end
    end

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic clear_mon();
        cyc = 0; busy_cyc = 0; wr_n = 0; rd_n = 0; done_n = 0; last_ld_cyc = 0; done_cyc = 0;
        pc_n = 0; x_n = 0; a_n = 0; b_n = 0; f_n = 0; sp_n = 0;
    endtask

    task automatic set_ctx(input logic [15:0] pc, input logic [15:0] x, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] f, input logic [15:0] sp);
        pc_in = pc; x_in = x; a_in = a; b_in = b; flg_in = f; sp_in = sp;
    endtask

    task automatic start(input logic [2:0] c);
        @(posedge clk); #1;
        clear_mon();
        mon_on = 1'b1;
        @(negedge clk); cmd_valid = 1'b1; cmd = c;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (done_n == 0 && k < 400) begin @(negedge clk); #1; k++; end
    endtask

    task automatic finish_checks(input int exp_busy);
        chk("R9", "busy cycles", busy_cyc, exp_busy);
        chk("R10", "done pulses", done_n, 1);
        chk("R10", "done after last load", (done_cyc > last_ld_cyc), 1);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] sp0;
        logic [7:0]  f0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        rst = 1'b1; cmd_valid = 1'b0; cmd = 3'd0; irq = 1'b0; nmi = 1'b0;
        set_ctx(16'h0, 16'h0, 8'h0, 8'h0, 8'h0, 16'h0);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R2", "busy after reset", busy, 0);
        chk("R2", "done after reset", done, 0);
        chk("R2", "strobes after reset", {mem_we, mem_re}, 0);
        chk("R2", "loads after reset", {pc_ld, x_ld, a_ld, b_ld, flg_ld, sp_ld}, 0);

        // software interrupt followed by interrupt return, several contexts
        for (int i = 0; i < 4; i++) begin
            logic [15:0] pc, x, sp;
            logic [7:0]  a, b, f;
            logic [7:0]  fr [0:6];
            pc = 16'h1234 + 16'(i) * 16'h1111;
            x  = 16'hA5C3 ^ 16'(i * 16'h0F0F);
            a  = 8'(8'h11 * i + 1);
            b  = ~a;
            f  = (i % 2 == 0) ? 8'hC1 : 8'hC6;
            sp = {8'(8'h20 + i), 8'(8'h60 + i * 8)};
            mem[8'hFA] = 8'(8'h80 + i);
            mem[8'hFB] = 8'(8'h40 + i * 3);
            fr[0] = pc[7:0]; fr[1] = pc[15:8]; fr[2] = x[7:0]; fr[3] = x[15:8];
            fr[4] = a; fr[5] = b; fr[6] = f;
            set_ctx(pc, x, a, b, f, sp);
            start(3'd0);
            wait_done();
            chk("R3", "frame writes", wr_n, 7);
            for (int k = 0; k < 7; k++) begin
                chk("R3", "frame address", wr_a[k], 16'(sp - 16'(k)));
                chk("R3", "frame byte", wr_d[k], fr[k]);
            end
            chk("R4", "vector reads", rd_n, 2);
            chk("R4", "vector high address", rd_a[0], 16'hFFFA);
            chk("R4", "vector low address", rd_a[1], 16'hFFFB);
            chk("R4", "pc", pc_g, {8'(8'h80 + i), 8'(8'h40 + i * 3)});
            chk("R4", "sp", sp_g, 16'(sp - 16'd7));
            chk("R4", "flags masked", f_g, f | 8'h10);
            chk("R4", "pc loads", pc_n, 1);
            finish_checks(12);

            set_ctx(16'h0, 16'h0, 8'h0, 8'h0, 8'h0, 16'(sp - 16'd7));
            start(3'd1);
            wait_done();
            chk("R5", "reads", rd_n, 7);
            for (int k = 0; k < 7; k++)
                chk("R5", "read address", rd_a[k], 16'(sp - 16'd6 + 16'(k)));
            chk("R5", "flags", f_g, f);
            chk("R5", "b", b_g, b);
            chk("R5", "a", a_g, a);
            chk("R5", "x", x_g, x);
            chk("R5", "pc", pc_g, pc);
            chk("R5", "sp", sp_g, sp);
            chk("R5", "x loads", x_n, 1);
            chk("R5", "writes", wr_n, 0);
            finish_checks(10);
        end

        // subroutine return
        for (int i = 0; i < 3; i++) begin
            logic [15:0] sp;
            sp = {8'h05, 8'(8'h30 + i * 20)};
            mem[8'(sp + 16'd1)] = 8'(8'h9A + i);
            mem[8'(sp + 16'd2)] = 8'(8'h27 * (i + 1));
            set_ctx(16'hFFFF, 16'h0, 8'h0, 8'h0, 8'h0, sp);
            start(3'd3);
            wait_done();
            chk("R6", "read high address", rd_a[0], 16'(sp + 16'd1));
            chk("R6", "read low address", rd_a[1], 16'(sp + 16'd2));
            chk("R6", "pc", pc_g, {8'(8'h9A + i), 8'(8'h27 * (i + 1))});
            chk("R6", "sp", sp_g, 16'(sp + 16'd2));
            finish_checks(5);
        end

        // push and pull of each accumulator
        for (int sel = 0; sel < 2; sel++) begin
            logic [7:0] v;
            v = (sel == 0) ? 8'h5A : 8'hC3;
            set_ctx(16'h0, 16'h0, 8'h5A, 8'hC3, 8'h0, 16'h0150);
            start(3'(4 + sel));
            wait_done();
            chk("R7", "push writes", wr_n, 1);
            chk("R7", "push address", wr_a[0], 16'h0150);
            chk("R7", "push byte", wr_d[0], v);
            chk("R7", "push sp", sp_g, 16'h014F);
            finish_checks(4);
            set_ctx(16'h0, 16'h0, 8'h00, 8'h00, 8'h0, 16'h014F);
            start(3'(6 + sel));
            wait_done();
            chk("R7", "pull address", rd_a[0], 16'h0150);
            chk("R7", "pull value", (sel == 0) ? a_g : b_g, v);
            chk("R7", "pull other acc untouched", (sel == 0) ? b_n : a_n, 0);
            chk("R7", "pull sp", sp_g, 16'h0150);
            finish_checks(4);
        end

        // wait, mask clear, request already present
        sp0 = 16'h0390; f0 = 8'h02;
        set_ctx(16'h4455, 16'h6677, 8'h88, 8'h99, f0, sp0);
        irq = 1'b1;
        start(3'd2);
        wait_done();
        irq = 1'b0;
        chk("R8", "frame writes", wr_n, 7);
        chk("R8", "flag byte stored", wr_d[6], f0);
        chk("R8", "sp", sp_g, 16'h0389);
        chk("R8", "flags masked on exit", f_g, f0 | 8'h10);
        finish_checks(10);

        // wait, mask set: irq ignored, only nmi leaves
        f0 = 8'h14;
        set_ctx(16'h0102, 16'h0304, 8'h05, 8'h06, f0, sp0);
        irq = 1'b1;
        start(3'd2);
        repeat (30) @(negedge clk);
        #1;
        chk("R8", "still waiting with irq masked", busy, 1);
        chk("R8", "no done while masked", done_n, 0);
        chk("R8", "sp loaded before wait", sp_n, 1);
        nmi = 1'b1;
        wait_done();
        nmi = 1'b0; irq = 1'b0;
        chk("R8", "nmi exit flags", f_g, f0);
        chk("R10", "done pulses", done_n, 1);

        // command presented while busy is ignored
        set_ctx(16'hBEEF, 16'h0, 8'h77, 8'h0, 8'h0, 16'h0220);
        @(posedge clk); #1;
        clear_mon();
        @(negedge clk); cmd_valid = 1'b1; cmd = 3'd4;
        @(negedge clk); cmd = 3'd3;
        @(negedge clk); cmd_valid = 1'b0;
        wait_done();
        repeat (4) @(negedge clk);
        #1;
        chk("R1", "writes of single push", wr_n, 1);
        chk("R1", "no reads from ignored request", rd_n, 0);
        chk("R1", "no pc load from ignored request", pc_n, 0);
        chk("R1", "idle afterwards", busy, 0);
        chk("R1", "single done", done_n, 1);
        chk("R2", "quiet when idle", {mem_we, mem_re, pc_ld, sp_ld}, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule